// File: doc/BRIEF.md
# GPIO Pin Controller with Wake-up Glitch Filter

This block gives software control of a bank of general-purpose pins through a small synchronous register port. Every pin has its own settings: whether it drives its pad, which of four multiplexed functions owns it, and a pull request of up, down or none. The pull request leaves the block as control bits only, because the pad electronics sit outside it. A parameter marks some pins as input-only, and such a pin never drives its pad.

Software reaches pin data in two ways. A per-pin register holds one bit. A port register covers sixteen pins and takes a write mask, so only the selected pins change. Both views read the same sampled pad level. For a pin that drives its pad, a read therefore returns what the pad really carries, not the value that was last written. Every pad input passes through a two-flop synchronizer. The lowest pins of the bank can also pass through a digital glitch filter with a programmable length. Each time a filtered pin changes level, a sticky wake-up flag is set. Software clears a flag by writing 1 to it, and the OR of all flags leaves the block as a wake request.

Top module: `gpio_pinctl`

## Requirements
- R1: After reset, all output enables, pull requests, function selects, output latches and wake flags are 0, the filter enable register reads 0, and the filter length register reads 0 (filter length of 1).
- R2: The pin configuration register at address 0x00+p has these fields: bit 0 is the output enable, bits [2:1] are the pull request, and bits [4:3] are the function select. Pull code 2'b10 requests pull-up and 2'b01 requests pull-down; codes 00 and 11 request no pull. Every field is reflected on the pad control outputs, and the register reads back as written.
- R3: On input-only pins, a write to the output-enable bit is ignored: the bit reads back 0 and the pad is never driven. The other fields of the register are still written.
- R4: A write to the per-pin data register at 0x20+p sets that pin's output latch from wdata bit 0. A read of that register returns, in bit 0, the sampled pad level, whether or not the pin is an output.
- R5: A write to the port register at 0x40+k uses wdata[31:16] as a mask and wdata[15:0] as data for pins 16k..16k+15. Only the pins whose mask bit is 1 change their output latch.
- R6: A read of the port register returns in bits [15:0] the same levels that the sixteen per-pin reads return, and 0 in bits [31:16].
- R7: When a pad changes level before clock edge E1 and the pin is not filtered, a read sampled at edge E2 still returns the old level, and a read sampled at E3 or later returns the new level.
- R8: The register at 0x60 holds N-1 in bits [3:0], and the register at 0x61 enables the filter on pins 0..FILT_PINS-1, with bit i for pin i. A filtered pin takes a new level only after N consecutive samples at that level. A step sampled at E1 is therefore read at E(3+N) at the earliest, and a pulse shorter than N samples is never seen.
- R9: A level change on a filtered pin sets bit i of the wake register at 0x62. The bit stays set until software writes 1 to it. If a new event arrives in the same cycle as the clear, the event wins. The wake_req output is the OR of all flags.
- R10: A pin whose filter is disabled follows its synchronized input with no extra delay, and its changes never set a wake flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered at the edge that samples bus_re |
| pad_in | input | NUM_PINS | Pad levels, asynchronous |
| pad_out | output | NUM_PINS | Output latch values |
| pad_oe | output | NUM_PINS | Pad drive enables |
| pad_pu | output | NUM_PINS | Pull-up requests |
| pad_pd | output | NUM_PINS | Pull-down requests |
| pad_func | output | 2*NUM_PINS | Function select, two bits per pin |
| wake_req | output | 1 | OR of all wake flags |

## Verification
Two functions can fall in the same cycle: a filtered level change that sets a wake flag, and a software write that clears that flag. The bench steps a filtered pin with a filter length of three. It counts edges from the pad change and issues the clear write so that the write is sampled at the exact edge where the filter passes the new level. It then expects the flag to read back as set. A clear on a later edge must leave the flag at 0. The same edge count, taken from R7 and R8, also checks the exact cycle at which filtered and unfiltered reads first return the new level.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 8;
    localparam int PORT_W = 16;
    localparam int FLEN_W = 4;

    // address regions, taken from bus_addr[7:5]
    localparam logic [2:0] RGN_CFG  = 3'd0;
    localparam logic [2:0] RGN_DATA = 3'd1;
    localparam logic [2:0] RGN_PORT = 3'd2;
    localparam logic [2:0] RGN_FILT = 3'd3;

    // registers inside the filter region, taken from bus_addr[4:0]
    localparam logic [4:0] FREG_LEN  = 5'd0;
    localparam logic [4:0] FREG_EN   = 5'd1;
    localparam logic [4:0] FREG_WAKE = 5'd2;

    localparam logic [1:0] PULL_DOWN = 2'b01;
    localparam logic [1:0] PULL_UP   = 2'b10;

    typedef struct packed {
        logic [1:0] func;
        logic [1:0] pull;
        logic       dir;
    } pin_cfg_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;

    // second stage always carries the first stage of one edge earlier
    p_stage_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.s2 == $past(st_q.s1)));

endmodule

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             din_i,
    output logic             level_o,
    output logic             event_o
);
    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } flt_t;

    flt_t st_d, st_q;
    logic evt_d;

    always_comb begin
        st_d  = st_q;
        evt_d = 1'b0;
        if (!en_i) begin
            st_d.lvl = din_i;
            st_d.cnt = '0;
        end else if (din_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= len_i) begin
            st_d.lvl = din_i;
            st_d.cnt = '0;
            evt_d    = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.lvl;
    assign event_o = evt_d;

    // an input that agrees with the held level never moves it
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (din_i == st_q.lvl)) |=> $stable(st_q.lvl));

    // disabled filter is transparent after one register
    p_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q.lvl == $past(din_i)));

    // a reported event always comes with a level change
    p_event_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> (st_q.lvl != $past(st_q.lvl)));

endmodule

// File: rtl/gpio_pinctl.sv
module gpio_pinctl
    import gpio_pkg::*;
#(
    parameter int                 NUM_PINS     = 32,
    parameter int                 FILT_PINS    = 8,
    parameter logic [NUM_PINS-1:0] IN_ONLY_MASK = {2'b11, {(NUM_PINS-2){1'b0}}}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic                  bus_re,
    input  logic [7:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_pu,
    output logic [NUM_PINS-1:0]   pad_pd,
    output logic [2*NUM_PINS-1:0] pad_func,
    output logic                  wake_req
);
    localparam int NUM_PORTS = NUM_PINS / PORT_W;

    typedef struct packed {
        pin_cfg_t [NUM_PINS-1:0] cfg;
        logic [NUM_PINS-1:0]     dout;
        logic [FILT_PINS-1:0]    fen;
        logic [FILT_PINS-1:0]    wake;
        logic [FLEN_W-1:0]       flen;
        logic [31:0]             rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0]           rgn;
    logic [4:0]           sel;
    logic [NUM_PINS-1:0]  pin_s;
    logic [NUM_PINS-1:0]  lvl;
    logic [FILT_PINS-1:0] flt_lvl;
    logic [FILT_PINS-1:0] flt_evt;
    logic [NUM_PINS-1:0]  port_mask;
    logic [NUM_PINS-1:0]  port_data;
    logic [FILT_PINS-1:0] wake_clr;

    assign rgn = bus_addr[7:5];
    assign sel = bus_addr[4:0];

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_in),
        .q_o   (pin_s)
    );

    for (genvar gi = 0; gi < FILT_PINS; gi++) begin : g_filt
        gpio_glitch_filter #(.CNT_W(FLEN_W)) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (r_q.fen[gi]),
            .len_i   (r_q.flen),
            .din_i   (pin_s[gi]),
            .level_o (flt_lvl[gi]),
            .event_o (flt_evt[gi])
        );
    end

    // level seen by software: filtered where the filter is on
    always_comb begin
        lvl = pin_s;
        for (int i = 0; i < FILT_PINS; i++) begin
            if (r_q.fen[i]) lvl[i] = flt_lvl[i];
        end
    end

    // port write mask and data spread over the whole pin vector
    always_comb begin
        port_mask = '0;
        port_data = '0;
        for (int k = 0; k < NUM_PORTS; k++) begin
            port_data[k*PORT_W +: PORT_W] = bus_wdata[PORT_W-1:0];
            if (bus_we && rgn == RGN_PORT && int'(sel) == k)
                port_mask[k*PORT_W +: PORT_W] = bus_wdata[31:PORT_W];
        end
        wake_clr = '0;
        if (bus_we && rgn == RGN_FILT && sel == FREG_WAKE)
            wake_clr = bus_wdata[FILT_PINS-1:0];
    end

    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            case (rgn)
                RGN_CFG: begin
                    for (int i = 0; i < NUM_PINS; i++) begin
                        if (int'(sel) == i) begin
                            r_d.cfg[i] = bus_wdata[4:0];
                            if (IN_ONLY_MASK[i]) r_d.cfg[i].dir = 1'b0;
                        end
                    end
                end
                RGN_DATA: begin
                    for (int i = 0; i < NUM_PINS; i++) begin
                        if (int'(sel) == i) r_d.dout[i] = bus_wdata[0];
                    end
                end
                RGN_PORT: r_d.dout = (r_q.dout & ~port_mask) | (port_data & port_mask);
                RGN_FILT: begin
                    case (sel)
                        FREG_LEN: r_d.flen = bus_wdata[FLEN_W-1:0];
                        FREG_EN:  r_d.fen  = bus_wdata[FILT_PINS-1:0];
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
        // a new event outranks a clear in the same cycle
        r_d.wake = (r_q.wake & ~wake_clr) | flt_evt;

        if (bus_re) begin
            r_d.rdata = '0;
            case (rgn)
                RGN_CFG: begin
                    for (int i = 0; i < NUM_PINS; i++)
                        if (int'(sel) == i) r_d.rdata[4:0] = r_q.cfg[i];
                end
                RGN_DATA: begin
                    for (int i = 0; i < NUM_PINS; i++)
                        if (int'(sel) == i) r_d.rdata[0] = lvl[i];
                end
                RGN_PORT: begin
                    for (int k = 0; k < NUM_PORTS; k++)
                        if (int'(sel) == k) r_d.rdata[PORT_W-1:0] = lvl[k*PORT_W +: PORT_W];
                end
                RGN_FILT: begin
                    case (sel)
                        FREG_LEN:  r_d.rdata[FLEN_W-1:0]    = r_q.flen;
                        FREG_EN:   r_d.rdata[FILT_PINS-1:0] = r_q.fen;
                        FREG_WAKE: r_d.rdata[FILT_PINS-1:0] = r_q.wake;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            pad_oe[i]         = r_q.cfg[i].dir;
            pad_pu[i]         = (r_q.cfg[i].pull == PULL_UP);
            pad_pd[i]         = (r_q.cfg[i].pull == PULL_DOWN);
            pad_func[2*i +: 2] = r_q.cfg[i].func;
        end
    end

    assign pad_out   = r_q.dout;
    assign bus_rdata = r_q.rdata;
    assign wake_req  = |r_q.wake;

    // input-only pins never drive
    p_inonly_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & IN_ONLY_MASK) == '0));

    // a port write leaves unmasked pins alone
    p_port_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && rgn == RGN_PORT) |=>
        (((pad_out ^ $past(pad_out)) & ~$past(port_mask)) == '0));

    // flags only drop under a clear write
    p_wake_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|r_q.wake) |=> (($past(r_q.wake) & ~$past(wake_clr) & ~r_q.wake) == '0));

    // a flag only rises on a pin whose filter is on
    p_wake_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fen != '1) |=> ((r_q.wake & ~$past(r_q.wake) & ~$past(r_q.fen)) == '0));

endmodule

// File: tb/tb_gpio_pinctl.sv
`timescale 1ns/1ps
module tb_gpio_pinctl;
    localparam int NP = 32;
    localparam int NF = 8;
    localparam logic [NP-1:0] INO = 32'hC000_0000;
    localparam logic [7:0] A_CFG = 8'h00, A_DATA = 8'h20, A_PORT = 8'h40;
    localparam logic [7:0] A_LEN = 8'h60, A_EN = 8'h61, A_WAKE = 8'h62;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NP-1:0] pad_in, pad_out, pad_oe, pad_pu, pad_pd;
    logic [2*NP-1:0] pad_func;
    logic wake_req;
    logic [NP-1:0] ext = '0, force_m = '0, mdl;
    int checks = 0, failures = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    assign pad_in = (force_m & ext) | (~force_m & ((pad_oe & pad_out) | (~pad_oe & ext)));

    gpio_pinctl #(.NUM_PINS(NP), .FILT_PINS(NF), .IN_ONLY_MASK(INO)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .pad_func(pad_func), .wake_req(wake_req));

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    // bus tasks: called at a negedge, use one rising edge, return at the next negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_re = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata;
        bus_re = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 oe", pad_oe, 32'h0);
        chk("R1 pu", pad_pu | pad_pd, 32'h0);
        chk("R1 func", pad_func[31:0] | pad_func[63:32], 32'h0);
        chk("R1 out", pad_out, 32'h0);
        chk("R1 wake_req", {31'h0, wake_req}, 32'h0);
        rd(A_LEN, rv); chk("R1 len", rv, 32'h0);
        rd(A_EN, rv);  chk("R1 en", rv, 32'h0);

        // R2 / R3: full sweep of config codes on every pin
        for (int p = 0; p < NP; p++) begin
            for (int v = 0; v < 32; v++) begin
                logic [4:0] c;
                logic [31:0] e;
                c = 5'(v);
                e = {27'h0, c};
                if (INO[p]) e[0] = 1'b0;
                wr(A_CFG + 8'(p), {27'h0, c});
                rd(A_CFG + 8'(p), rv);
                chk(INO[p] ? "R3 cfg readback" : "R2 cfg readback", rv, e);
                chk(INO[p] ? "R3 oe" : "R2 oe", {31'h0, pad_oe[p]}, {31'h0, e[0]});
                chk("R2 pu", {31'h0, pad_pu[p]}, {31'h0, c[2:1] == 2'b10});
                chk("R2 pd", {31'h0, pad_pd[p]}, {31'h0, c[2:1] == 2'b01});
                chk("R2 func", {30'h0, pad_func[2*p +: 2]}, {30'h0, c[4:3]});
            end
            wr(A_CFG + 8'(p), 32'h0);
        end

        // R4: per-pin data, pins 0..15 outputs, 16..31 inputs
        ext = 32'hA5C3_0000;
        for (int p = 0; p < 16; p++) wr(A_CFG + 8'(p), 32'h1);
        for (int p = 0; p < 16; p++) begin
            wr(A_DATA + 8'(p), 32'h1);
            idle(2);
            rd(A_DATA + 8'(p), rv);
            chk("R4 out pin reads 1", rv, 32'h1);
            chk("R4 pad_out", {31'h0, pad_out[p]}, 32'h1);
            wr(A_DATA + 8'(p), 32'h0);
            idle(2);
            rd(A_DATA + 8'(p), rv);
            chk("R4 out pin reads 0", rv, 32'h0);
        end
        wr(A_DATA + 8'd31, 32'h1);
        idle(2);
        for (int p = 16; p < NP; p++) begin
            rd(A_DATA + 8'(p), rv);
            chk("R4 input level", rv, {31'h0, ext[p]});
        end
        chk("R4 latch of input pin", {31'h0, pad_out[31]}, 32'h1);
        wr(A_DATA + 8'd5, 32'h1);
        force_m[5] = 1'b1;
        idle(3);
        rd(A_DATA + 8'd5, rv);
        chk("R4 pad level beats latch", rv, 32'h0);
        force_m = '0;

        // R5 / R6: masked port writes and port reads
        for (int p = 0; p < NP; p++) wr(A_CFG + 8'(p), 32'h1);
        wr(A_PORT, 32'hFFFF_0000);
        wr(A_PORT + 8'd1, 32'hFFFF_0000);
        mdl = '0;
        ext = 32'h4000_0000;
        for (int t = 0; t < 24; t++) begin
            int k;
            logic [15:0] m, dat;
            logic [NP-1:0] lv;
            k = t % 2;
            m = (t == 0) ? 16'h0 : 16'(t * 16'h2F1D + 16'h0137);
            dat = 16'(t * 16'h9E37) ^ 16'h5A5A;
            wr(A_PORT + 8'(k), {m, dat});
            for (int j = 0; j < 16; j++) if (m[j]) mdl[16*k + j] = dat[j];
            chk("R5 masked port write", pad_out, mdl);
            idle(2);
            lv = (~INO & mdl) | (INO & ext);
            rd(A_PORT + 8'(k), rv);
            chk("R6 port read", rv, {16'h0, lv[16*k +: 16]});
            if (t % 6 == 1) begin
                for (int j = 0; j < 16; j++) begin
                    rd(A_DATA + 8'(16*k + j), rv);
                    chk("R6 pin view matches port", rv, {31'h0, lv[16*k + j]});
                end
            end
        end
        for (int p = 0; p < NP; p++) wr(A_CFG + 8'(p), 32'h0);
        ext = '0;
        idle(3);

        // R7: synchronizer latency on unfiltered pin 20
        ext[20] = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            rd(A_DATA + 8'd20, rv);
            chk("R7 sync latency", rv, {31'h0, k >= 3});
        end

        // R8 / R9: filter length sweep on pin 3
        wr(A_EN, 32'h8);
        for (int n = 1; n <= 16; n++) begin
            wr(A_LEN, 32'(n - 1));
            idle(n + 4);
            wr(A_WAKE, 32'hFF);
            if (n > 1) begin
                ext[3] = 1'b1;
                repeat (n - 1) @(negedge clk);
                ext[3] = 1'b0;
                idle(n + 4);
                rd(A_DATA + 8'd3, rv);
                chk("R8 short pulse rejected", rv, 32'h0);
                rd(A_WAKE, rv);
                chk("R8 no wake on short pulse", rv, 32'h0);
            end
            ext[3] = 1'b1;
            repeat (n) @(negedge clk);
            ext[3] = 1'b0;
            idle(n + 6);
            rd(A_WAKE, rv);
            chk("R9 wake on full pulse", rv, 32'h8);
            chk("R9 wake_req", {31'h0, wake_req}, 32'h1);
            ext[3] = 1'b1;
            idle(n + 4);
            rd(A_DATA + 8'd3, rv);
            chk("R8 step passes", rv, 32'h1);
            ext[3] = 1'b0;
            idle(n + 4);
        end

        // R8 exact cycle with N=3
        wr(A_LEN, 32'h2);
        wr(A_WAKE, 32'hFF);
        ext[3] = 1'b1;
        for (int k = 1; k <= 7; k++) begin
            rd(A_DATA + 8'd3, rv);
            chk("R8 filter latency", rv, {31'h0, k >= 6});
        end

        // R9 event and clear on the same edge (event at E5)
        ext[3] = 1'b0;
        idle(4);
        wr(A_WAKE, 32'h8);
        rd(A_WAKE, rv);
        chk("R9 set wins over clear", rv, 32'h8);
        wr(A_WAKE, 32'h8);
        rd(A_WAKE, rv);
        chk("R9 write one clears", rv, 32'h0);
        chk("R9 wake_req low", {31'h0, wake_req}, 32'h0);
        ext[3] = 1'b1;
        idle(5);
        wr(A_WAKE, 32'h8);
        rd(A_WAKE, rv);
        chk("R9 clear after event", rv, 32'h0);

        // R10: filter disabled on pin 3
        wr(A_EN, 32'h0);
        ext[3] = 1'b0;
        idle(4);
        ext[3] = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            rd(A_DATA + 8'd3, rv);
            chk("R10 bypass latency", rv, {31'h0, k >= 3});
        end
        ext[3] = 1'b0;
        @(negedge clk);
        ext[3] = 1'b1;
        @(negedge clk);
        ext[3] = 1'b0;
        idle(5);
        rd(A_WAKE, rv);
        chk("R10 no wake when disabled", rv, 32'h0);
        chk("R10 wake_req", {31'h0, wake_req}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule